// File: doc/BRIEF.md
# Configuration Memory Auto-Loader

This block runs right after a system reset. It reads an external byte-wide configuration memory through a simple request/acknowledge read port and copies the memory image into a 512-byte shadow RAM. Other logic later reads descriptor and configuration bytes from that RAM through a one-cycle-latency read port. The first byte read is a signature. When the signature is missing, or the memory does not answer in time, the block stops. It then presents fixed default values on its configuration field outputs. Two strap inputs adjust the default flags byte.

A load request input with a mode bit starts a new load. A full load serves power-on, pin and software resets. A MAC-only load serves a bus reset and refreshes just the six address bytes. While any load is running, the block holds its bus-disconnect output high. It also rejects host read commands, and each rejected command sets an error flag. Once the load finishes or is abandoned, the host reads the shadow RAM through a command/data pair.

Top module: `cal_autoload`

## Requirements
- R1: After reset release, and in the cycle after any load request, the block requests memory address 0 first.
- R2: When the byte at address 0 is 0xA5, a full load reads addresses 0 to 511 in rising order and writes each byte into the shadow RAM at the same address. When the load ends, sig_ok_o is 1.
- R3: After a load with a good signature, the field outputs take these shadow RAM bytes: MAC bytes 1..6 with byte 1 in bits 7:0, full-speed poll at 7, high-speed poll at 8, flags at 9, max power at 10, and vendor ID with the low byte at 11 and the high byte at 12.
- R4: Any other byte at address 0 ends a full load after that one read and sets sig_ok_o to 0. The fields then become the defaults: MAC 0xFFFFFFFFFFFF, full-speed poll 0x01, high-speed poll 0x04, max power 0xFA, vendor ID 0x0424.
- R5: The default flags byte is 0x04, with bit 6 set from strap_pwr_i and bit 5 set from strap_wake_i.
- R6: A MAC-only load reads addresses 0 to 6 only and changes only the MAC field. If its signature is bad, only the MAC goes to all ones. Other fields and shadow RAM bytes above 6 keep their values.
- R7: busy_o and phy_disc_o are 1 from reset until the load ends, whether it succeeds or aborts, and they return to 1 during any later load.
- R8: rd_req_o stays high with a stable rd_addr_o until rd_ack_i arrives. The next address is issued only after that acknowledge.
- R9: If no acknowledge arrives within ACK_TIMEOUT cycles, the load aborts exactly as for a bad signature.
- R10: A host command while busy is rejected: host_err_o becomes 1 and host_rvalid_o stays 0. An accepted command gives host_rvalid_o and the RAM byte one cycle later, and clears host_err_o.
- R11: The consumer read port returns the shadow RAM byte at cons_addr_i one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; a full load starts on release |
| load_req_i | input | 1 | One-cycle pulse that starts a new load |
| load_mac_only_i | input | 1 | With load_req_i: 1 selects a MAC-only load |
| strap_pwr_i | input | 1 | Power-select strap, sets default flags bit 6 |
| strap_wake_i | input | 1 | Remote-wakeup strap, sets default flags bit 5 |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 9 | Memory read address |
| rd_ack_i | input | 1 | Memory read acknowledge, one cycle per read |
| rd_data_i | input | 8 | Memory read data, valid with rd_ack_i |
| busy_o | output | 1 | Load in progress |
| phy_disc_o | output | 1 | Holds the bus PHY disconnected |
| sig_ok_o | output | 1 | Last load found a good signature and finished |
| cons_addr_i | input | 9 | Consumer read address |
| cons_data_o | output | 8 | Consumer read data, one cycle latency |
| host_req_i | input | 1 | Host read command |
| host_addr_i | input | 9 | Host read address |
| host_rdata_o | output | 8 | Host read data |
| host_rvalid_o | output | 1 | Host read data valid |
| host_err_o | output | 1 | Last host command was rejected |
| mac_o | output | 48 | MAC address field |
| fs_poll_o | output | 8 | Full-speed polling interval |
| hs_poll_o | output | 8 | High-speed polling interval |
| cfg_flags_o | output | 8 | Configuration flags |
| max_pwr_o | output | 8 | Maximum power |
| vid_o | output | 16 | Vendor ID |

## Verification
Four behaviours are checked by assertions on every cycle:
- address 0 comes first after a load request;
- the request address holds steady until it is acknowledged;
- a MAC-only load never reaches past byte 6;
- a host command issued while busy is always rejected.

Only the bench scenarios can show the rest. That covers the field values after a good, bad or silent memory, the strap effect on the defaults, and the shadow RAM contents seen through both read ports. It also covers what a MAC-only load leaves untouched and how long the disconnect is held.

// File: rtl/cal_pkg.sv
package cal_pkg;
   typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_READ = 1'b1} ld_state_t;

   localparam logic [7:0] SIG_BYTE   = 8'hA5;
   localparam int         OFF_MAC    = 1;
   localparam int         OFF_FSPOLL = 7;
   localparam int         OFF_HSPOLL = 8;
   localparam int         OFF_FLAGS  = 9;
   localparam int         OFF_MAXPWR = 10;
   localparam int         OFF_VID_LO = 11;
   localparam int         OFF_VID_HI = 12;

   localparam logic [7:0]  DEF_FSPOLL = 8'h01;
   localparam logic [7:0]  DEF_HSPOLL = 8'h04;
   localparam logic [7:0]  DEF_FLAGS  = 8'h04;
   localparam logic [7:0]  DEF_MAXPWR = 8'hFA;
   localparam logic [15:0] DEF_VID    = 16'h0424;
   localparam int          FLAG_PWR_BIT  = 6;
   localparam int          FLAG_WAKE_BIT = 5;
endpackage

// File: rtl/cal_shadow_ram.sv
module cal_shadow_ram #(
   parameter int AW = 9,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic [AW-1:0] ra_addr_i,
   output logic [DW-1:0] ra_data_o,
   input  logic [AW-1:0] rb_addr_i,
   output logic [DW-1:0] rb_data_o
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
      ra_data_o <= mem[ra_addr_i];
      rb_data_o <= mem[rb_addr_i];
   end
endmodule

// File: rtl/cal_seq.sv
module cal_seq
   import cal_pkg::*;
#(
   parameter int AW          = 9,
   parameter int MEM_BYTES   = 512,
   parameter int MAC_BYTES   = 6,
   parameter int ACK_TIMEOUT = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_req_i,
   input  logic          load_mac_only_i,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_ack_i,
   input  logic [7:0]    rd_data_i,
   output logic          wr_en_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [7:0]    wr_data_o,
   output logic          apply_def_o,
   output logic          def_mac_only_o,
   output logic          busy_o,
   output logic          sig_ok_o
);
   localparam int            WW        = $clog2(ACK_TIMEOUT + 1);
   localparam logic [AW-1:0] LAST_FULL = AW'(MEM_BYTES - 1);
   localparam logic [AW-1:0] LAST_MAC  = AW'(MAC_BYTES);
   localparam logic [WW-1:0] WAIT_MAX  = WW'(ACK_TIMEOUT - 1);

   ld_state_t     state_q;
   logic [AW-1:0] addr_q;
   logic          mac_mode_q;
   logic [WW-1:0] wait_q;
   logic          sig_ok_q;

   logic          reading, at_sig, sig_bad, timed_out;
   logic [AW-1:0] last_addr;

   assign reading   = (state_q == ST_READ);
   assign at_sig    = (addr_q == '0);
   assign sig_bad   = rd_ack_i && at_sig && (rd_data_i != SIG_BYTE);
   assign timed_out = !rd_ack_i && (wait_q == WAIT_MAX);
   assign last_addr = mac_mode_q ? LAST_MAC : LAST_FULL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_READ;
         addr_q     <= '0;
         mac_mode_q <= 1'b0;
         wait_q     <= '0;
         sig_ok_q   <= 1'b0;
      end else if (load_req_i) begin
         state_q    <= ST_READ;
         addr_q     <= '0;
         mac_mode_q <= load_mac_only_i;
         wait_q     <= '0;
         sig_ok_q   <= 1'b0;
      end else if (reading) begin
         if (rd_ack_i) begin
            wait_q <= '0;
            if (sig_bad) begin
               state_q <= ST_IDLE;
            end else if (addr_q == last_addr) begin
               state_q  <= ST_IDLE;
               sig_ok_q <= 1'b1;
            end else begin
               addr_q <= addr_q + 1'b1;
            end
         end else if (timed_out) begin
            state_q <= ST_IDLE;
            wait_q  <= '0;
         end else begin
            wait_q <= wait_q + 1'b1;
         end
      end
   end

   assign rd_req_o       = reading;
   assign rd_addr_o      = addr_q;
   assign wr_en_o        = reading && rd_ack_i && !sig_bad && !load_req_i;
   assign wr_addr_o      = addr_q;
   assign wr_data_o      = rd_data_i;
   assign apply_def_o    = reading && !load_req_i && (sig_bad || timed_out);
   assign def_mac_only_o = mac_mode_q;
   assign busy_o         = reading;
   assign sig_ok_o       = sig_ok_q;

   // R1: a load request always restarts at the signature address
   p_sig_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load_req_i |=> (rd_req_o && rd_addr_o == '0));

   // R8: address held while a read is outstanding
   p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i && !load_req_i) |=> (!rd_req_o || $stable(rd_addr_o)));

   // R6: a MAC-only load stays inside the address bytes
   p_mac_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && mac_mode_q) |-> (rd_addr_o <= LAST_MAC));
endmodule

// File: rtl/cal_fields.sv
module cal_fields
   import cal_pkg::*;
#(
   parameter int AW        = 9,
   parameter int MAC_BYTES = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en_i,
   input  logic [AW-1:0]          wr_addr_i,
   input  logic [7:0]             wr_data_i,
   input  logic                   apply_def_i,
   input  logic                   def_mac_only_i,
   input  logic                   strap_pwr_i,
   input  logic                   strap_wake_i,
   output logic [8*MAC_BYTES-1:0] mac_o,
   output logic [7:0]             fs_poll_o,
   output logic [7:0]             hs_poll_o,
   output logic [7:0]             cfg_flags_o,
   output logic [7:0]             max_pwr_o,
   output logic [15:0]            vid_o
);
   logic [7:0] strap_flags;

   always_comb begin
      strap_flags                = DEF_FLAGS;
      strap_flags[FLAG_PWR_BIT]  = strap_pwr_i;
      strap_flags[FLAG_WAKE_BIT] = strap_wake_i;
   end

   function automatic logic hit(input logic [AW-1:0] a, input int off);
      return a == AW'(off);
   endfunction

   for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                mac_o[8*g +: 8] <= 8'hFF;
         else if (apply_def_i)                      mac_o[8*g +: 8] <= 8'hFF;
         else if (wr_en_i && hit(wr_addr_i, OFF_MAC + g)) mac_o[8*g +: 8] <= wr_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_poll_o   <= DEF_FSPOLL;
         hs_poll_o   <= DEF_HSPOLL;
         cfg_flags_o <= DEF_FLAGS;
         max_pwr_o   <= DEF_MAXPWR;
         vid_o       <= DEF_VID;
      end else if (apply_def_i) begin
         if (!def_mac_only_i) begin
            fs_poll_o   <= DEF_FSPOLL;
            hs_poll_o   <= DEF_HSPOLL;
            cfg_flags_o <= strap_flags;
            max_pwr_o   <= DEF_MAXPWR;
            vid_o       <= DEF_VID;
         end
      end else if (wr_en_i) begin
         if (hit(wr_addr_i, OFF_FSPOLL)) fs_poll_o   <= wr_data_i;
         if (hit(wr_addr_i, OFF_HSPOLL)) hs_poll_o   <= wr_data_i;
         if (hit(wr_addr_i, OFF_FLAGS))  cfg_flags_o <= wr_data_i;
         if (hit(wr_addr_i, OFF_MAXPWR)) max_pwr_o   <= wr_data_i;
         if (hit(wr_addr_i, OFF_VID_LO)) vid_o[7:0]  <= wr_data_i;
         if (hit(wr_addr_i, OFF_VID_HI)) vid_o[15:8] <= wr_data_i;
      end
   end
endmodule

// File: rtl/cal_autoload.sv
module cal_autoload
   import cal_pkg::*;
#(
   parameter int AW          = 9,
   parameter int MEM_BYTES   = 512,
   parameter int MAC_BYTES   = 6,
   parameter int ACK_TIMEOUT = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_req_i,
   input  logic                   load_mac_only_i,
   input  logic                   strap_pwr_i,
   input  logic                   strap_wake_i,
   output logic                   rd_req_o,
   output logic [AW-1:0]          rd_addr_o,
   input  logic                   rd_ack_i,
   input  logic [7:0]             rd_data_i,
   output logic                   busy_o,
   output logic                   phy_disc_o,
   output logic                   sig_ok_o,
   input  logic [AW-1:0]          cons_addr_i,
   output logic [7:0]             cons_data_o,
   input  logic                   host_req_i,
   input  logic [AW-1:0]          host_addr_i,
   output logic [7:0]             host_rdata_o,
   output logic                   host_rvalid_o,
   output logic                   host_err_o,
   output logic [8*MAC_BYTES-1:0] mac_o,
   output logic [7:0]             fs_poll_o,
   output logic [7:0]             hs_poll_o,
   output logic [7:0]             cfg_flags_o,
   output logic [7:0]             max_pwr_o,
   output logic [15:0]            vid_o
);
   if (MEM_BYTES != (1 << AW)) begin : g_bad_depth
      $error("MEM_BYTES must equal 2**AW");
   end
   if (MAC_BYTES + OFF_VID_HI > MEM_BYTES) begin : g_bad_map
      $error("field map does not fit the memory");
   end
   if (ACK_TIMEOUT < 2) begin : g_bad_to
      $error("ACK_TIMEOUT must be at least 2");
   end

   logic          wr_en, apply_def, def_mac_only, busy;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_data;

   cal_seq #(.AW(AW), .MEM_BYTES(MEM_BYTES), .MAC_BYTES(MAC_BYTES),
             .ACK_TIMEOUT(ACK_TIMEOUT)) u_seq (
      .clk, .rst_n, .load_req_i, .load_mac_only_i,
      .rd_req_o, .rd_addr_o, .rd_ack_i, .rd_data_i,
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .apply_def_o(apply_def), .def_mac_only_o(def_mac_only),
      .busy_o(busy), .sig_ok_o
   );

   cal_shadow_ram #(.AW(AW), .DW(8)) u_ram (
      .clk, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .ra_addr_i(cons_addr_i), .ra_data_o(cons_data_o),
      .rb_addr_i(host_addr_i), .rb_data_o(host_rdata_o)
   );

   cal_fields #(.AW(AW), .MAC_BYTES(MAC_BYTES)) u_fields (
      .clk, .rst_n, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .apply_def_i(apply_def), .def_mac_only_i(def_mac_only),
      .strap_pwr_i, .strap_wake_i,
      .mac_o, .fs_poll_o, .hs_poll_o, .cfg_flags_o, .max_pwr_o, .vid_o
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rvalid_o <= 1'b0;
         host_err_o    <= 1'b0;
      end else begin
         host_rvalid_o <= host_req_i && !busy;
         if (host_req_i) host_err_o <= busy;
      end
   end

   assign busy_o     = busy;
   assign phy_disc_o = busy;

   // R10: host commands during a load are refused
   p_host_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req_i && busy_o) |=> (host_err_o && !host_rvalid_o));
endmodule

// File: tb/cal_autoload_bench.sv
`timescale 1ns/1ps
module cal_autoload_bench;
   localparam int AW = 9;
   localparam int TO = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic load_req = 1'b0, load_mac = 1'b0, s_pwr = 1'b1, s_wake = 1'b0;
   logic rd_req, rd_ack = 1'b0;
   logic [AW-1:0] rd_addr;
   logic [7:0] rd_data = '0;
   logic busy, disc, sig_ok;
   logic [AW-1:0] cons_addr = '0, host_addr = '0;
   logic [7:0] cons_data, host_rdata;
   logic host_req = 1'b0, host_rvalid, host_err;
   logic [47:0] mac;
   logic [7:0] fs, hs, flags, mpwr;
   logic [15:0] vid;

   always #2.5 clk = ~clk;

   cal_autoload #(.AW(AW), .MEM_BYTES(512), .MAC_BYTES(6), .ACK_TIMEOUT(TO)) u_cal_autoload (
      .clk, .rst_n, .load_req_i(load_req), .load_mac_only_i(load_mac),
      .strap_pwr_i(s_pwr), .strap_wake_i(s_wake),
      .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
      .busy_o(busy), .phy_disc_o(disc), .sig_ok_o(sig_ok),
      .cons_addr_i(cons_addr), .cons_data_o(cons_data),
      .host_req_i(host_req), .host_addr_i(host_addr), .host_rdata_o(host_rdata),
      .host_rvalid_o(host_rvalid), .host_err_o(host_err),
      .mac_o(mac), .fs_poll_o(fs), .hs_poll_o(hs), .cfg_flags_o(flags),
      .max_pwr_o(mpwr), .vid_o(vid)
   );

   int errors = 0, checks = 0;
   logic [7:0] sig = 8'hA5, seed = 8'h3C;
   int lat = 1, wcnt = 0, nreads = 0, maxaddr = 0;
   logic silent = 1'b0;

   function automatic logic [7:0] mbyte(input int a, input logic [7:0] sg, input logic [7:0] sd);
      if (a == 0) return sg;
      return 8'(a) ^ sd ^ ((a >= 256) ? 8'h5A : 8'h00);
   endfunction

   // external memory model, driven on the falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         rd_ack <= 1'b0; wcnt <= 0;
      end else if (rd_ack) begin
         rd_ack <= 1'b0; wcnt <= 0;
      end else if (rd_req && !silent) begin
         if (wcnt >= lat) begin
            rd_ack  <= 1'b1;
            rd_data <= mbyte(int'(rd_addr), sig, seed);
            nreads  <= nreads + 1;
            if (int'(rd_addr) > maxaddr) maxaddr <= int'(rd_addr);
         end else wcnt <= wcnt + 1;
      end else wcnt <= 0;
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      while (busy && n < 5000) begin @(negedge clk); n++; end
      check({req, " load ends"}, 64'(busy), 64'd0);
   endtask

   task automatic start_load(input logic mac_only);
      nreads = 0; maxaddr = 0;
      @(negedge clk); load_req = 1'b1; load_mac = mac_only;
      @(negedge clk); load_req = 1'b0;
   endtask

   task automatic chk_fields_mem(input string req, input logic [7:0] sd);
      logic [47:0] em;
      for (int i = 0; i < 6; i++) em[8*i +: 8] = mbyte(1 + i, 8'hA5, sd);
      check({req, " mac"}, 64'(mac), 64'(em));
      check({req, " fs"}, 64'(fs), 64'(mbyte(7, 8'hA5, sd)));
      check({req, " hs"}, 64'(hs), 64'(mbyte(8, 8'hA5, sd)));
      check({req, " flags"}, 64'(flags), 64'(mbyte(9, 8'hA5, sd)));
      check({req, " mpwr"}, 64'(mpwr), 64'(mbyte(10, 8'hA5, sd)));
      check({req, " vid"}, 64'(vid), 64'({mbyte(12, 8'hA5, sd), mbyte(11, 8'hA5, sd)}));
   endtask

   task automatic chk_defaults(input string req, input logic [7:0] eflags);
      check({req, " mac"}, 64'(mac), 64'h0000_FFFF_FFFF_FFFF);
      check({req, " fs"}, 64'(fs), 64'h01);
      check({req, " hs"}, 64'(hs), 64'h04);
      check({req, " flags"}, 64'(flags), 64'(eflags));
      check({req, " mpwr"}, 64'(mpwr), 64'hFA);
      check({req, " vid"}, 64'(vid), 64'h0424);
   endtask

   task automatic cons_read(input string req, input int a, input logic [7:0] exp);
      cons_addr = AW'(a);
      @(negedge clk);
      check(req, 64'(cons_data), 64'(exp));
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 reset addr", 64'(rd_addr), 64'd0);
      check("R1 reset req", 64'(rd_req), 64'd1);
      check("R7 reset disc", 64'(disc), 64'd1);
      check("R7 reset busy", 64'(busy), 64'd1);
      check("R10 reset err", 64'(host_err), 64'd0);
   endtask

   task automatic t_full_good;
      wait_idle("R2");
      check("R2 sig ok", 64'(sig_ok), 64'd1);
      check("R7 disc released", 64'(disc), 64'd0);
      chk_fields_mem("R3", seed);
      cons_read("R11 cons 0", 0, 8'hA5);
      cons_read("R11 cons 1", 1, mbyte(1, sig, seed));
      cons_read("R2 cons 300", 300, mbyte(300, sig, seed));
      cons_read("R2 cons 511", 511, mbyte(511, sig, seed));
   endtask

   task automatic t_host;
      @(negedge clk); host_req = 1'b1; host_addr = 9'd100;
      @(negedge clk); host_req = 1'b0;
      check("R10 rvalid", 64'(host_rvalid), 64'd1);
      check("R10 rdata", 64'(host_rdata), 64'(mbyte(100, sig, seed)));
      check("R10 no err", 64'(host_err), 64'd0);
      nreads = 0; maxaddr = 0;
      @(negedge clk); load_req = 1'b1; load_mac = 1'b0;
      @(negedge clk); load_req = 1'b0; host_req = 1'b1;
      check("R7 busy again", 64'(disc), 64'd1);
      @(negedge clk); host_req = 1'b0;
      check("R10 rejected err", 64'(host_err), 64'd1);
      check("R10 rejected no rvalid", 64'(host_rvalid), 64'd0);
      wait_idle("R10");
      @(negedge clk); host_req = 1'b1; host_addr = 9'd5;
      @(negedge clk); host_req = 1'b0;
      check("R10 err cleared", 64'(host_err), 64'd0);
      check("R10 rdata 5", 64'(host_rdata), 64'(mbyte(5, sig, seed)));
   endtask

   task automatic t_mac_only;
      logic [7:0] old = seed;
      seed = 8'hC3;
      start_load(1'b1);
      wait_idle("R6");
      check("R6 max addr", 64'(maxaddr), 64'd6);
      check("R6 reads", 64'(nreads), 64'd7);
      check("R6 sig ok", 64'(sig_ok), 64'd1);
      for (int i = 0; i < 6; i++)
         check("R6 mac byte", 64'(mac[8*i +: 8]), 64'(mbyte(1 + i, sig, seed)));
      check("R6 fs kept", 64'(fs), 64'(mbyte(7, 8'hA5, old)));
      check("R6 vid kept", 64'(vid), 64'({mbyte(12, 8'hA5, old), mbyte(11, 8'hA5, old)}));
      cons_read("R6 ram 300 kept", 300, mbyte(300, sig, old));
      sig = 8'h00;
      start_load(1'b1);
      wait_idle("R6 bad");
      check("R6 bad mac", 64'(mac), 64'h0000_FFFF_FFFF_FFFF);
      check("R6 bad fs kept", 64'(fs), 64'(mbyte(7, 8'hA5, old)));
      check("R6 bad sig_ok", 64'(sig_ok), 64'd0);
      sig = 8'hA5; seed = old;
   endtask

   task automatic t_bad_sig;
      sig = 8'h5A; s_pwr = 1'b1; s_wake = 1'b0;
      start_load(1'b0);
      wait_idle("R4");
      check("R4 one read", 64'(nreads), 64'd1);
      check("R4 sig_ok", 64'(sig_ok), 64'd0);
      check("R7 disc after abort", 64'(disc), 64'd0);
      chk_defaults("R4", 8'h44);
      s_pwr = 1'b0; s_wake = 1'b1;
      start_load(1'b0);
      wait_idle("R5");
      check("R5 flags wake", 64'(flags), 64'h24);
      sig = 8'hA5;
   endtask

   task automatic t_timeout;
      start_load(1'b0);
      wait_idle("R3 reload");
      chk_fields_mem("R3 reload", seed);
      silent = 1'b1; s_pwr = 1'b0; s_wake = 1'b0;
      start_load(1'b0);
      repeat (TO - 4) @(negedge clk);
      check("R9 still busy", 64'(disc), 64'd1);
      repeat (8) @(negedge clk);
      check("R9 aborted", 64'(busy), 64'd0);
      chk_defaults("R9", 8'h04);
      silent = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_full_good();
      t_host();
      t_mac_only();
      t_bad_sig();
      t_timeout();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule